// File: doc/BRIEF.md
# Configuration Packet Stream Decoder

This block sits on a 16-bit configuration word stream and splits it into packets. Each header word gives a packet class, an opcode, a target register and a short inline length. The decoder then steers the payload words that follow to outputs for each register. It decodes frame-address words into their column, row, block and frame fields. It pulses an output for every word written to the command register, with a dedicated strobe for the write-configuration command. It streams frame-data words out with a running index and a completion pulse.

Short transfers use a single-level header: a class-1 header carries its payload length inline. Bulk frame data uses a second-level scheme: a class-2 header has a zero inline length, and the next two words give a 32-bit word count, most significant half first. Every accepted word is consumed in one cycle, and the input is never back-pressured. All decoded outputs are registered and appear in the cycle after the word is accepted.

Top module: `cfg_pkt_decoder`

## Requirements
- R1: `in_ready` is always high. A header splits into class `[15:13]`, opcode `[12:11]` (value 2 = write), register `[10:5]` and inline length `[4:0]`. Example: 0x3022 is class 1, write, register 1, length 2.
- R2: The first payload word of a class-1 write to register 1 is the major address. The block reports it with `far_major_valid`, as column `[7:0]`, row `[11:8]` and block `[15:12]`. Example: 0x000D gives column 13, row 0, block 0.
- R3: The second payload word of that packet is the minor address. The block reports it with `far_minor_valid`, as frame `[9:0]` and block-RAM select bit 14. Example: 0x0015 gives frame 21 with the select clear.
- R4: Each payload word of a class-1 write to register 5 pulses `cmd_valid` with the word on `cmd_code`. `wcfg_pulse` pulses for one cycle only when the word is 0x0001.
- R5: After a class-2 write header to register 3 (such as 0x5060), the next two words form the count, high half first. The block then emits that many words on `fd_valid`/`fd_data`, with `fd_index` counting from 0.
- R6: `fd_done` is high together with `fd_valid` on the last counted word only.
- R7: A class-1 packet to any other register, or one whose opcode is not write, consumes exactly its inline length of words. Those words cause no output and no error, even when they look like headers.
- R8: A header whose class is neither 1 nor 2 sets the sticky `err_flag`, and the next word is decoded as a header.
- R9: A synchronous active-high `rst` clears `err_flag` and all output pulses, and returns the decoder to waiting for a header.
- R10: A cycle with `in_valid` low consumes nothing and produces no output pulse. At most one decoded output pulses in any cycle.
- R11: A class-1 write to register 3 with a nonzero inline length streams that many frame words, indexed from 0, with `fd_done` on the last.
- R12: A class-2 count of zero emits no frame word and no `fd_done`, and the next word is decoded as a header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word valid |
| in_data | input | 16 | Configuration word |
| in_ready | output | 1 | Always high |
| far_major_valid | output | 1 | Major address word decoded |
| far_block | output | 4 | Block type field |
| far_row | output | 4 | Row field |
| far_column | output | 8 | Major column field |
| far_minor_valid | output | 1 | Minor address word decoded |
| far_frame | output | 10 | Minor frame field |
| far_bram | output | 1 | Block-RAM select |
| cmd_valid | output | 1 | Command word written |
| cmd_code | output | 16 | Command word value |
| wcfg_pulse | output | 1 | Write-configuration command strobe |
| fd_valid | output | 1 | Frame-data word valid |
| fd_data | output | 16 | Frame-data word |
| fd_index | output | 32 | Index of the frame-data word within its packet |
| fd_done | output | 1 | Last counted frame-data word |
| err_flag | output | 1 | Sticky bad-class error |

## Verification
The bench sweeps class-2 packets of one to eight words, with and without idle gaps. It checks every index and data word, and that `fd_done` falls on the last word alone. A decoder that swapped the count halves would take the count as tens of thousands of words and would swallow the command packet that follows. A decoder with an off-by-one in the counter would lose or add a word, or pulse `fd_done` in the wrong place. The discard packets carry payload words that look like a bad header, a frame-address header and a frame-data header. A decoder that parsed discarded payload as headers would raise the error flag or report spurious fields. The bench also sends a zero count, sweeps frame-address field values, and sweeps command codes, where only 0x0001 may strobe.

// File: rtl/cfg_pkt_decoder.sv
module cfg_pkt_decoder #(
  parameter logic [5:0] REG_FAR  = 6'd1,
  parameter logic [5:0] REG_FDRI = 6'd3,
  parameter logic [5:0] REG_CMD  = 6'd5,
  parameter logic [15:0] CMD_WCFG = 16'h0001
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic [15:0] in_data,
  output logic        in_ready,
  output logic        far_major_valid,
  output logic [3:0]  far_block,
  output logic [3:0]  far_row,
  output logic [7:0]  far_column,
  output logic        far_minor_valid,
  output logic [9:0]  far_frame,
  output logic        far_bram,
  output logic        cmd_valid,
  output logic [15:0] cmd_code,
  output logic        wcfg_pulse,
  output logic        fd_valid,
  output logic [15:0] fd_data,
  output logic [31:0] fd_index,
  output logic        fd_done,
  output logic        err_flag
);
  localparam int CNT_W = 32;
  localparam logic [1:0] OP_WRITE = 2'd2;

  typedef enum logic [2:0] {S_HDR, S_PAY, S_WCH, S_WCL, S_FDAT} state_t;
  state_t st;

  logic [5:0]       reg_q;
  logic             wr_q;
  logic [4:0]       pos;
  logic [15:0]      wc_hi;
  logic [CNT_W-1:0] rem, idx;

  wire [2:0]       h_cls  = in_data[15:13];
  wire             h_wr   = in_data[12:11] == OP_WRITE;
  wire [5:0]       h_reg  = in_data[10:5];
  wire [4:0]       h_len  = in_data[4:0];
  wire             stream = wr_q && reg_q == REG_FDRI;
  wire             last   = rem == CNT_W'(1);
  wire [CNT_W-1:0] wcount = {wc_hi, in_data};

  assign in_ready = 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_HDR;
      reg_q <= '0;
      wr_q <= 1'b0;
      pos <= '0;
      wc_hi <= '0;
      rem <= '0;
      idx <= '0;
      far_major_valid <= 1'b0;
      far_block <= '0;
      far_row <= '0;
      far_column <= '0;
      far_minor_valid <= 1'b0;
      far_frame <= '0;
      far_bram <= 1'b0;
      cmd_valid <= 1'b0;
      cmd_code <= '0;
      wcfg_pulse <= 1'b0;
      fd_valid <= 1'b0;
      fd_data <= '0;
      fd_index <= '0;
      fd_done <= 1'b0;
      err_flag <= 1'b0;
    end else begin
      far_major_valid <= 1'b0;
      far_minor_valid <= 1'b0;
      cmd_valid <= 1'b0;
      wcfg_pulse <= 1'b0;
      fd_valid <= 1'b0;
      fd_done <= 1'b0;
      if (in_valid) begin
        case (st)
          S_HDR: begin
            reg_q <= h_reg;
            wr_q <= h_wr;
            pos <= '0;
            idx <= '0;
            if (h_cls == 3'd1) begin
              rem <= CNT_W'(h_len);
              if (h_len != 5'd0)
                st <= (h_wr && h_reg == REG_FDRI) ? S_FDAT : S_PAY;
            end else if (h_cls == 3'd2) begin
              st <= S_WCH;
            end else begin
              err_flag <= 1'b1;
            end
          end
          S_PAY: begin
            if (wr_q && reg_q == REG_FAR && pos == 5'd0) begin
              far_major_valid <= 1'b1;
              far_block <= in_data[15:12];
              far_row <= in_data[11:8];
              far_column <= in_data[7:0];
            end
            if (wr_q && reg_q == REG_FAR && pos == 5'd1) begin
              far_minor_valid <= 1'b1;
              far_frame <= in_data[9:0];
              far_bram <= in_data[14];
            end
            if (wr_q && reg_q == REG_CMD) begin
              cmd_valid <= 1'b1;
              cmd_code <= in_data;
              wcfg_pulse <= in_data == CMD_WCFG;
            end
            pos <= pos + 5'd1;
            rem <= rem - CNT_W'(1);
            if (last) st <= S_HDR;
          end
          S_WCH: begin
            wc_hi <= in_data;
            st <= S_WCL;
          end
          S_WCL: begin
            rem <= wcount;
            st <= (wcount == '0) ? S_HDR : S_FDAT;
          end
          S_FDAT: begin
            if (stream) begin
              fd_valid <= 1'b1;
              fd_data <= in_data;
              fd_index <= idx;
              fd_done <= last;
            end
            idx <= idx + CNT_W'(1);
            rem <= rem - CNT_W'(1);
            if (last) st <= S_HDR;
          end
          default: st <= S_HDR;
        endcase
      end
    end
  end
endmodule

// File: rtl/cfg_pkt_decoder_chk.sv
module cfg_pkt_decoder_chk (
  input logic clk,
  input logic rst,
  input logic in_ready,
  input logic fd_valid,
  input logic fd_done,
  input logic cmd_valid,
  input logic wcfg_pulse,
  input logic far_major_valid,
  input logic far_minor_valid,
  input logic err_flag
);
  assert_always_ready_R1: assert property (@(posedge clk) disable iff (rst) in_ready);
  assert_done_with_word_R6: assert property (@(posedge clk) disable iff (rst) fd_done |-> fd_valid);
  assert_wcfg_is_cmd_R4: assert property (@(posedge clk) disable iff (rst) wcfg_pulse |-> cmd_valid);
  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst) err_flag |=> err_flag);
  assert_reset_quiet_R9: assert property (@(posedge clk)
    rst |=> !fd_valid && !cmd_valid && !err_flag && !far_major_valid && !far_minor_valid);
  assert_one_event_R10: assert property (@(posedge clk) disable iff (rst)
    $countones({fd_valid, cmd_valid, far_major_valid, far_minor_valid}) <= 1);
endmodule

bind cfg_pkt_decoder cfg_pkt_decoder_chk u_chk (.*);

// File: tb/cfg_pkt_decoder_tb.sv
module cfg_pkt_decoder_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic in_ready, far_major_valid, far_minor_valid, far_bram, cmd_valid, wcfg_pulse;
  logic fd_valid, fd_done, err_flag;
  logic [3:0] far_block, far_row;
  logic [7:0] far_column;
  logic [9:0] far_frame;
  logic [15:0] cmd_code, fd_data;
  logic [31:0] fd_index;

  always #2 clk = ~clk;

  cfg_pkt_decoder u_dut (.*);

  int n_chk = 0, n_bad = 0;
  bit gap_mode = 0;
  bit finished = 0;

  int n_fd, n_done, done_at, n_cmd, n_wcfg, n_maj, n_min;
  logic [15:0] fd_d [64];
  logic [31:0] fd_i [64];
  logic [15:0] maj_w, min_w;

  always @(negedge clk) if (!rst) begin
    if (fd_valid) begin
      if (n_fd < 64) begin fd_d[n_fd] = fd_data; fd_i[n_fd] = fd_index; end
      n_fd++;
      if (fd_done) begin n_done++; done_at = n_fd; end
    end
    if (cmd_valid) n_cmd++;
    if (wcfg_pulse) n_wcfg++;
    if (far_major_valid) begin n_maj++; maj_w = {far_block, far_row, far_column}; end
    if (far_minor_valid) begin n_min++; min_w = {1'b0, far_bram, 4'b0, far_frame}; end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(input logic [15:0] w);
    if (gap_mode) begin @(negedge clk); in_valid = 0; in_data = 16'hFFFF; end
    @(negedge clk); in_valid = 1; in_data = w;
  endtask

  task automatic idle();
    @(negedge clk); in_valid = 0; in_data = 16'h2000;
    repeat (3) @(negedge clk);
  endtask

  task automatic clr();
    n_fd = 0; n_done = 0; done_at = -1; n_cmd = 0; n_wcfg = 0; n_maj = 0; n_min = 0;
    maj_w = 'x; min_w = 'x;
  endtask

  task automatic far_test(input logic [15:0] mj, input logic [15:0] mn);
    clr();
    put(16'h3022); put(mj); put(mn); idle();
    check(n_maj == 1 && maj_w == mj, "R2 major fields", maj_w, mj);
    check(n_min == 1 && min_w == (mn & 16'h43FF), "R3 minor fields", min_w, mn & 16'h43FF);
  endtask

  initial begin
    clr();
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(in_ready === 1'b1, "R1 ready", in_ready, 1);
    check(!fd_valid && !err_flag && !cmd_valid, "R9 reset outputs", {fd_valid, err_flag, cmd_valid}, 0);

    far_test(16'h000D, 16'h0015);
    for (int k = 0; k < 8; k++)
      far_test({4'(k), 4'(k + 3), 8'(k * 29 + 1)}, {1'b0, k[0], 4'b0, 10'(k * 97)});

    for (int c = 0; c < 8; c++) begin
      clr();
      put(16'h30A1); put(16'(c)); idle();
      check(n_cmd == 1, "R4 cmd_valid", n_cmd, 1);
      check(n_wcfg == (c == 1), "R4 wcfg strobe", n_wcfg, c == 1);
    end

    for (int n = 1; n <= 8; n++) begin
      gap_mode = n[0];
      clr();
      put(16'h5060); put(16'h0000); put(16'(n));
      for (int i = 0; i < n; i++) put(16'hA000 + 16'(n * 16 + i));
      put(16'h30A1); put(16'h0001);
      idle();
      check(n_fd == n, gap_mode ? "R10 word count with gaps" : "R5 word count", n_fd, n);
      for (int i = 0; i < n; i++) begin
        check(fd_i[i] == 32'(i), "R5 index", fd_i[i], i);
        check(fd_d[i] == 16'hA000 + 16'(n * 16 + i), "R5 data", fd_d[i], 16'hA000 + n * 16 + i);
      end
      check(n_done == 1 && done_at == n, "R6 done on last", done_at, n);
      check(n_wcfg == 1, "R5 header after count high-first", n_wcfg, 1);
    end
    gap_mode = 0;

    for (int n = 1; n <= 4; n++) begin
      clr();
      put(16'h3060 | 16'(n));
      for (int i = 0; i < n; i++) put(16'h5000 + 16'(i));
      idle();
      check(n_fd == n && n_done == 1 && done_at == n, "R11 inline frame data", n_fd, n);
      check(fd_i[n-1] == 32'(n - 1) && fd_d[n-1] == 16'h5000 + 16'(n - 1), "R11 last word",
            fd_d[n-1], 16'h5000 + n - 1);
    end

    clr();
    put(16'h30E3); put(16'hE000); put(16'h3022); put(16'h5060);
    put(16'h2822); put(16'h00FF); put(16'h0011);
    idle();
    check(!err_flag && n_maj == 0 && n_min == 0 && n_fd == 0 && n_cmd == 0, "R7 discard",
          {err_flag, 8'(n_maj), 8'(n_fd)}, 0);
    far_test(16'h1234, 16'h4003);

    clr();
    put(16'h5060); put(16'h0000); put(16'h0000); put(16'h30A1); put(16'h0001); idle();
    check(n_fd == 0 && n_done == 0, "R12 zero count no data", n_fd, 0);
    check(n_wcfg == 1, "R12 header after zero count", n_wcfg, 1);

    clr();
    check(err_flag == 0, "R8 no error before", err_flag, 0);
    put(16'hE000); put(16'h30A1); put(16'h0001); idle();
    check(err_flag == 1, "R8 error set", err_flag, 1);
    check(n_wcfg == 1, "R8 resumes header wait", n_wcfg, 1);
    clr();
    put(16'h5060); put(16'h0000); put(16'h0002); put(16'h1111); put(16'h2222); idle();
    check(err_flag == 1, "R8 error sticky", err_flag, 1);
    check(n_fd == 2, "R8 decoding continues", n_fd, 2);

    clr();
    put(16'h5060); put(16'h0000); put(16'h0005); put(16'h7777);
    @(negedge clk); in_valid = 0; rst = 1;
    @(negedge clk); rst = 0;
    check(err_flag == 0 && fd_valid == 0, "R9 reset clears", err_flag, 0);
    clr();
    put(16'h30A1); put(16'h0001); idle();
    check(n_wcfg == 1 && n_fd == 0, "R9 header wait after reset", n_wcfg, 1);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule